// File: doc/BRIEF.md
# MDIO PHY Presence and Link Tracker

This block keeps two status vectors for a management bus that can reach up to 32 PHYs. Bit n of each vector belongs to the PHY at management address n. The MDIO transaction engine reports each finished transaction with a single-cycle completion event. The event carries the PHY address, the register number, the direction (read or write), the acknowledge result and, for reads, the 16-bit data returned. The block uses these events to keep a presence vector, which says whether a PHY answered its latest access. It also keeps a link vector, which says whether a PHY reported link up the last time its basic status register was read.

Software reaches both vectors through a small word-addressed register port. Writes take effect at the clock edge, and reads are combinational. Software may clear presence bits by writing ones to them. The link vector cannot be written by software. Events that come from user requests and events that come from automatic polling are treated the same way, so the event carries no source field.

Top module: `mdio_phy_tracker`

## Requirements
- R1: Bit n of each vector belongs to management address n. The presence vector reads at word offset 0 and the link vector at word offset 1. Offsets 2 and 3 read as zero. Read data is combinational from `reg_addr` and shows the state as of the last clock edge.
- R2: A completion event with acknowledge set makes the presence bit of its address 1 after the next clock edge. An event without acknowledge makes that bit 0. Presence bits of all other addresses stay unchanged.
- R3: Read events and write events update presence in the same way, whatever their register number.
- R4: A register write to offset 0 clears every presence bit whose write-data bit is 1. Presence bits whose write-data bit is 0 keep their value.
- R5: After reset, every presence bit and every link bit is 0.
- R6: Only an event that is a read of register number 1 changes the link vector. Write events and reads of any other register number leave the link vector unchanged.
- R7: On an event that reads register 1, the link bit of the addressed PHY becomes 1 when the read was acknowledged and bit 2 of the read data is 1. Otherwise it becomes 0.
- R8: Register writes to offset 1, or to any offset other than 0, change neither vector.
- R9: If a completion event and a clear-on-write hit the same presence bit in the same cycle, the bit takes the event's acknowledge value. The write still clears the other bits it selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | Completion event strobe, one cycle per transaction |
| evt_phy | input | 5 | PHY management address of the transaction |
| evt_reg | input | 5 | Register number accessed |
| evt_is_read | input | 1 | 1 for a read transaction, 0 for a write |
| evt_ack | input | 1 | 1 when the PHY acknowledged |
| evt_rdata | input | 16 | Data returned by a read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The bench builds the block with its default parameters: 32 PHY addresses, status register 1 and link indication at bit 2. With these values every bit position of both vectors can be reached, and the bench sweeps all 32 addresses with acknowledged, unacknowledged, link-up and link-down events. A reference model in the bench computes each next vector with bit arithmetic, so walking patterns, clear masks and same-cycle conflicts on every address are all compared against independently derived values.

// File: rtl/mdio_trk_pkg.sv
// Package: shared register offsets for the PHY presence and link tracker.
// Assumes a two-bit word offset on the register port.
package mdio_trk_pkg;
    typedef enum logic [1:0] {
        OFS_PRESENCE = 2'd0,
        OFS_LINK     = 2'd1
    } trk_ofs_e;
endpackage

// File: rtl/mdio_trk_decode.sv
// Module: mdio_trk_decode
// Turns one completion event into a one-hot address hit mask, the acknowledge
// result, a status-read strobe and the link value that read carries.
// Assumes evt_valid lasts one cycle per completed transaction.
module mdio_trk_decode #(
    parameter int unsigned NUM_PHY    = 32,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REGN_W     = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned STATUS_REG = 1,
    parameter int unsigned LINK_BIT   = 2
) (
    input  logic               evt_valid,
    input  logic [ADDR_W-1:0]  evt_phy,
    input  logic [REGN_W-1:0]  evt_reg,
    input  logic               evt_is_read,
    input  logic               evt_ack,
    input  logic [DATA_W-1:0]  evt_rdata,
    output logic [NUM_PHY-1:0] hit_mask,
    output logic               ack,
    output logic               stat_upd,
    output logic               link_val
);
    localparam logic [DATA_W-1:0] LINK_MASK = DATA_W'(1) << LINK_BIT;

    // One comparator per address produces the hit mask.
    for (genvar i = 0; i < NUM_PHY; i++) begin : g_hit
        assign hit_mask[i] = evt_valid && (evt_phy == ADDR_W'(i));
    end

    // Classify the event and extract the link indication.
    always_comb begin
        ack      = evt_ack;
        stat_upd = evt_valid && evt_is_read && (evt_reg == REGN_W'(STATUS_REG));
        link_val = evt_ack && (|(evt_rdata & LINK_MASK));
    end
endmodule

// File: rtl/mdio_trk_presence.sv
// Module: mdio_trk_presence
// Presence vector. An event hit loads the acknowledge result. Otherwise a
// software clear mask resets the selected bits. A hit has priority over a clear.
module mdio_trk_presence #(
    parameter int unsigned NUM_PHY = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PHY-1:0] hit_mask,
    input  logic               ack,
    input  logic [NUM_PHY-1:0] clr_mask,
    output logic [NUM_PHY-1:0] pres_q
);
    for (genvar i = 0; i < NUM_PHY; i++) begin : g_bit
        // Per-bit update: reset, then event result, then software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           pres_q[i] <= 1'b0;
            else if (hit_mask[i]) pres_q[i] <= ack;
            else if (clr_mask[i]) pres_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_trk_link.sv
// Module: mdio_trk_link
// Link vector. Only a status-register read changes it, and only at the
// addressed bit. Software cannot write it.
module mdio_trk_link #(
    parameter int unsigned NUM_PHY = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PHY-1:0] hit_mask,
    input  logic               stat_upd,
    input  logic               link_val,
    output logic [NUM_PHY-1:0] link_q
);
    for (genvar i = 0; i < NUM_PHY; i++) begin : g_bit
        // Per-bit update on a status read aimed at this address.
        always_ff @(posedge clk) begin
            if (!rst_n)                        link_q[i] <= 1'b0;
            else if (stat_upd && hit_mask[i])  link_q[i] <= link_val;
        end
    end
endmodule

// File: rtl/mdio_phy_tracker.sv
// Module: mdio_phy_tracker (top)
// Tracks PHY presence and link state from MDIO completion events and exposes
// both vectors on a word-addressed register port with combinational reads.
// Assumes NUM_PHY equals the register data width.
module mdio_phy_tracker #(
    parameter int unsigned NUM_PHY    = 32,
    parameter int unsigned REGN_W     = 5,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned STATUS_REG = 1,
    parameter int unsigned LINK_BIT   = 2,
    localparam int unsigned ADDR_W    = $clog2(NUM_PHY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [ADDR_W-1:0]  evt_phy,
    input  logic [REGN_W-1:0]  evt_reg,
    input  logic               evt_is_read,
    input  logic               evt_ack,
    input  logic [DATA_W-1:0]  evt_rdata,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_PHY-1:0] reg_wdata,
    output logic [NUM_PHY-1:0] reg_rdata
);
    import mdio_trk_pkg::*;

    logic [NUM_PHY-1:0] hit_mask;
    logic               ev_ack;
    logic               stat_upd;
    logic               link_val;
    logic [NUM_PHY-1:0] clr_mask;
    logic [NUM_PHY-1:0] pres_vec;
    logic [NUM_PHY-1:0] link_vec;

    mdio_trk_decode #(
        .NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W), .REGN_W(REGN_W),
        .DATA_W(DATA_W), .STATUS_REG(STATUS_REG), .LINK_BIT(LINK_BIT)
    ) u_dec (
        .evt_valid(evt_valid), .evt_phy(evt_phy), .evt_reg(evt_reg),
        .evt_is_read(evt_is_read), .evt_ack(evt_ack), .evt_rdata(evt_rdata),
        .hit_mask(hit_mask), .ack(ev_ack), .stat_upd(stat_upd), .link_val(link_val)
    );

    // Software clear mask: only writes to the presence offset clear bits.
    always_comb begin
        clr_mask = (reg_wr && (reg_addr == OFS_PRESENCE)) ? reg_wdata : '0;
    end

    mdio_trk_presence #(.NUM_PHY(NUM_PHY)) u_pres (
        .clk(clk), .rst_n(rst_n), .hit_mask(hit_mask), .ack(ev_ack),
        .clr_mask(clr_mask), .pres_q(pres_vec)
    );

    mdio_trk_link #(.NUM_PHY(NUM_PHY)) u_link (
        .clk(clk), .rst_n(rst_n), .hit_mask(hit_mask), .stat_upd(stat_upd),
        .link_val(link_val), .link_q(link_vec)
    );

    // Read mux: presence, link, else zero.
    always_comb begin
        case (reg_addr)
            OFS_PRESENCE: reg_rdata = pres_vec;
            OFS_LINK:     reg_rdata = link_vec;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_trk_chk.sv
// Module: mdio_trk_chk
// Assertion checker bound to the tracker top. It watches the event inputs,
// the register port and both internal vectors.
module mdio_trk_chk #(
    parameter int unsigned NUM_PHY    = 32,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned REGN_W     = 5,
    parameter int unsigned STATUS_REG = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               evt_valid,
    input logic [ADDR_W-1:0]  evt_phy,
    input logic [REGN_W-1:0]  evt_reg,
    input logic               evt_is_read,
    input logic               evt_ack,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [NUM_PHY-1:0] reg_wdata,
    input logic [NUM_PHY-1:0] pres_vec,
    input logic [NUM_PHY-1:0] link_vec
);
    logic stat_rd;
    logic pres_wr;
    assign stat_rd = evt_valid && evt_is_read && (evt_reg == REGN_W'(STATUS_REG));
    assign pres_wr = reg_wr && (reg_addr == 2'd0);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (pres_vec == '0) && (link_vec == '0)); // R5
    AST_PRES_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ack) |=> pres_vec[$past(evt_phy)]); // R2
    AST_PRES_NACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ack) |=> !pres_vec[$past(evt_phy)]); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_wr && !evt_valid) |=> ((pres_vec & $past(reg_wdata)) == '0)); // R4
    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_wr && !evt_valid) |=>
        ((pres_vec & ~$past(reg_wdata)) == ($past(pres_vec) & ~$past(reg_wdata)))); // R4
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> $stable(link_vec)); // R6
    AST_LINK_NACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt_ack) |=> !link_vec[$past(evt_phy)]); // R7
    AST_PRES_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !pres_wr) |=> $stable(pres_vec)); // R8
endmodule

bind mdio_phy_tracker mdio_trk_chk #(
    .NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W), .REGN_W(REGN_W), .STATUS_REG(STATUS_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_phy(evt_phy),
    .evt_reg(evt_reg), .evt_is_read(evt_is_read), .evt_ack(evt_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pres_vec(pres_vec), .link_vec(link_vec)
);

// File: tb/tb_mdio_phy_tracker.sv
`timescale 1ns/1ps
// Bench: sweeps every PHY address with a bench-side arithmetic model of both
// vectors and compares register reads after each cycle.
module tb_mdio_phy_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_phy = '0;
    logic [4:0]  evt_reg = '0;
    logic        evt_is_read = 1'b0;
    logic        evt_ack = 1'b0;
    logic [15:0] evt_rdata = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] m_pres = '0;
    logic [31:0] m_link = '0;

    always #2.5 clk = ~clk;

    mdio_phy_tracker dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_phy(evt_phy),
        .evt_reg(evt_reg), .evt_is_read(evt_is_read), .evt_ack(evt_ack),
        .evt_rdata(evt_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check_word(input logic [1:0] ofs, input logic [31:0] exp, input string req);
        reg_addr = ofs;
        #0.5;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s ofs=%0d actual=%08h expected=%08h", req, ofs, reg_rdata, exp);
        end
    endtask

    task automatic check_all(input string req);
        check_word(2'd0, m_pres, req);
        check_word(2'd1, m_link, req);
    endtask

    // One clock with an optional event and optional register write; updates the model, then checks.
    task automatic step(input logic ev, input int phy, input int rn, input logic rd,
                        input logic ack, input logic [15:0] dat,
                        input logic wr, input logic [1:0] ofs, input logic [31:0] wd,
                        input string req);
        logic [31:0] bit_n;
        bit_n = 32'd1 << phy;
        evt_valid = ev; evt_phy = 5'(phy); evt_reg = 5'(rn); evt_is_read = rd;
        evt_ack = ack; evt_rdata = dat;
        reg_wr = wr; reg_addr = ofs; reg_wdata = wd;
        // model: clear first, then hardware result overrides (R9)
        if (wr && ofs == 2'd0) m_pres = m_pres & ~wd;
        if (ev) m_pres = ack ? (m_pres | bit_n) : (m_pres & ~bit_n);
        if (ev && rd && rn == 1)
            m_link = (ack && dat[2]) ? (m_link | bit_n) : (m_link & ~bit_n);
        @(posedge clk);
        @(negedge clk);
        evt_valid = 1'b0; reg_wr = 1'b0;
        check_all(req);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R5 reset");
        check_word(2'd2, 32'h0, "R1 unused offset");
        check_word(2'd3, 32'h0, "R1 unused offset");

        // R2/R3: acknowledged write events on even addresses, random register numbers
        for (int i = 0; i < 32; i += 2)
            step(1, i, (i * 7) % 32, 0, 1, 16'hFFFF, 0, 0, 0, "R3 write event sets presence");
        // R1 R6 R7: status reads with ack on every address, link up when address is a multiple of 3
        for (int i = 0; i < 32; i++)
            step(1, i, 1, 1, 1, (i % 3 == 0) ? 16'h0004 : 16'hFFFB, 0, 0, 0, "R7 status read link");
        // R6: reads of other registers and writes to reg 1 with link-up data leave link alone
        for (int i = 0; i < 32; i++)
            step(1, i, (i % 2 == 0) ? 0 : 5, 1, 1, 16'h0004, 0, 0, 0, "R6 other register read");
        for (int i = 0; i < 32; i++)
            step(1, i, 1, 0, 1, 16'h0000, 0, 0, 0, "R6 write to status register");
        // R7 R2: unacknowledged status reads on multiples of 4 drop both bits, even with link data
        for (int i = 0; i < 32; i += 4)
            step(1, i, 1, 1, 0, 16'hFFFF, 0, 0, 0, "R7 nack clears link");
        // R2: unacknowledged write event on odd addresses
        for (int i = 1; i < 32; i += 6)
            step(1, i, 9, 0, 0, 16'h0000, 0, 0, 0, "R2 nack clears presence");
        // R8: writes to link and unused offsets
        step(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFFFFFF, "R8 link write ignored");
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFFFFFF, "R8 offset 2 write ignored");
        step(0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFFFFFF, "R8 offset 3 write ignored");
        // R4: clear with walking single bits and patterns
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0000, "R4 zero write keeps");
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_00F0, "R4 partial clear");
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'hA5A5_0000, "R4 pattern clear");
        // refill presence
        for (int i = 0; i < 32; i++)
            step(1, i, 3, 1, 1, 16'h0, 0, 0, 0, "R3 read event sets presence");
        // R9: conflict on every address, event ack vs full clear, and nack vs zero clear
        for (int i = 0; i < 32; i++) begin
            step(1, i, 0, 0, 1, 16'h0, 1, 2'd0, 32'hFFFFFFFF, "R9 ack beats clear");
            step(1, (i + 5) % 32, 2, 1, 0, 16'h0, 1, 2'd0, 32'h0, "R9 nack with zero write");
        end
        for (int i = 0; i < 32; i++)
            step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'd1 << i, "R4 walking clear");
        check_word(2'd2, 32'h0, "R1 unused offset after traffic");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule